// File: doc/BRIEF.md
# Static Memory Zone Bus-Cycle Sequencer

This block turns core-side access requests into external bus cycles for one chip-select zone of an off-chip static memory port. A 16-bit configuration register holds the zone timing: the count of wait cycles and hold cycles, a single-cycle fast-read mode, the bus width, a burst mode for 16-bit reads over a byte-wide bus, an extra wait for each burst beat, and two switches that add idle cycles when the target zone changes.

The core raises `reqValid` with the address, direction, access size, write data and a zone tag, and keeps them steady until `done` pulses. `done` lasts one cycle, and a read result is valid on `rdData` from that cycle on. The request must be dropped in the `done` cycle. The block never accepts a request while `done` is high. On the memory side the block drives the address, a zone select, read and write strobes, the write data and its output enable, and samples `busDin` in the final strobe cycle.

Each beat runs as follows. A setup cycle comes first with the select on and the strobes off. Then come one strobe cycle and the programmed wait cycles with the strobe on. Last come the hold cycles, with the select on and the strobes off.

Top module: `zoneseq_top`

## Requirements
- R1: The configuration register resets to 16'h069F. Bits 15:12 and bit 8 always read as zero and ignore writes. All other bits read back as written. Field positions: wait 2:0, hold 4:3, burst enable 5, burst wait 6, bus width 7 (1 = 16-bit), post-idle 9, pre-idle 10, fast read 11.
- R2: A normal single beat keeps the select on for 2+W+H cycles and a strobe on for 1+W cycles, where W is the wait field and H is the hold field.
- R3: With fast read set, a read beat takes exactly one select cycle with the read strobe on, whatever W and H are. Writes keep the normal timing.
- R4: On a 16-bit bus a 16-bit access is one beat that transfers the whole word. An 8-bit read returns the byte lane picked by address bit 0 (1 = bits 15:8), zero-extended.
- R5: On an 8-bit bus a 16-bit access runs as two beats. The first goes to the even address and carries the low byte. The second goes to the odd address and carries the high byte. Without burst, both beats use the full beat timing.
- R6: With burst enable set on an 8-bit bus, the second beat of a 16-bit non-fast read is a single strobe cycle, plus one cycle if burst wait is set. Burst affects neither writes nor a 16-bit bus, and burst wait has no effect while burst enable is clear.
- R7: When the zone tag differs from that of the previous access, (pre-idle + post-idle) idle cycles with the select off come before the first beat. No idle cycle is added for the same zone or for the first access after reset.
- R8: `done` is a one-cycle pulse in the cycle after the last bus cycle. Read and write strobes are never on together, and a strobe is only on while the select is on.
- R9: Write data goes out with the output enable on: the full word on a 16-bit bus for 16-bit writes, and otherwise the current byte copied onto both lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 16 | Configuration write value |
| cfgRdata | output | 16 | Configuration read-back |
| reqValid | input | 1 | Access request, held until done |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| reqAddr | input | AW | Byte address |
| reqZone | input | ZW | Target zone tag |
| reqWdata | input | 16 | Write data (low byte for 8-bit writes) |
| rdData | output | 16 | Read result, valid from done |
| done | output | 1 | One-cycle completion pulse |
| busAddr | output | AW | External address |
| busSel | output | 1 | Zone select, active high |
| busRd | output | 1 | Read strobe, active high |
| busWr | output | 1 | Write strobe, active high |
| busDout | output | 16 | External write data |
| busDin | input | 16 | External read data |
| busOe | output | 1 | Write data output enable |

## Verification
The bench sweeps every wait and hold count on a 16-bit bus and predicts each access length from the requirement formulas. A counter that is off by one, or a hold phase that is skipped, therefore shows up as a latency mismatch. It then crosses fast read, burst enable and burst wait on a byte-wide bus. A design that let fast read keep the wait cycles, bursted writes, or gave a burst beat setup or hold would report the wrong strobe or select count. Split accesses check the address of the first strobe, so a high-byte-first order is caught. The idle tests switch zones under all four pre/post settings and repeat the same zone, which exposes a gap inserted without a zone change or left out on one.

// File: rtl/zoneseq_pkg.sv
package zoneseq_pkg;
  localparam int DW = 16;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic       fastRd;
    logic       preIdle;
    logic       postIdle;
    logic       busWide;
    logic       burstWait;
    logic       burstEn;
    logic [1:0] hold;
    logic [2:0] waitCnt;
  } cfg_t;

  typedef struct packed {
    logic load;
    logic capture;
    logic beatHi;
  } ctl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_SETUP, S_STROBE, S_WAIT, S_HOLD
  } state_t;
endpackage

// File: rtl/zoneseq_cfg.sv
module zoneseq_cfg
  import zoneseq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [DW-1:0] cfgWdata,
  output logic [DW-1:0] cfgRdata,
  output cfg_t          cfg
);
  localparam logic [DW-1:0] RESET_VAL = 16'h069F;
  localparam logic [DW-1:0] KEEP_MASK = 16'h0EFF;
  localparam int B_FAST = 11, B_PRE = 10, B_POST = 9, B_WIDE = 7;
  localparam int B_BWAIT = 6, B_BURST = 5, B_HOLD = 3, B_WAIT = 0;

  logic [DW-1:0] regQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      regQ <= RESET_VAL;
    else if (cfgWe) regQ <= cfgWdata & KEEP_MASK;
  end

  assign cfgRdata      = regQ;
  assign cfg.fastRd    = regQ[B_FAST];
  assign cfg.preIdle   = regQ[B_PRE];
  assign cfg.postIdle  = regQ[B_POST];
  assign cfg.busWide   = regQ[B_WIDE];
  assign cfg.burstWait = regQ[B_BWAIT];
  assign cfg.burstEn   = regQ[B_BURST];
  assign cfg.hold      = regQ[B_HOLD +: 2];
  assign cfg.waitCnt   = regQ[B_WAIT +: 3];

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata[15:12] == 4'h0) && !cfgRdata[8]); // R1
endmodule

// File: rtl/zoneseq_ctrl.sv
module zoneseq_ctrl
  import zoneseq_pkg::*;
#(
  parameter int ZW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  cfg_t          cfg,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic          reqWide,
  input  logic [ZW-1:0] reqZone,
  output ctl_t          ctl,
  output logic          busSel,
  output logic          busRd,
  output logic          busWr,
  output logic          busOe,
  output logic          done
);
  state_t        state;
  logic [2:0]    cnt;
  logic          opWrite, opFast, opSplit, opBurst, beatHi;
  logic [ZW-1:0] lastZone;
  logic          lastValid, doneQ;

  logic       accept, newFast, zoneChg;
  logic [1:0] gapN;
  logic [2:0] waitN;
  logic [1:0] holdN;
  logic       lastStrobe, endBeat, endStrobe;

  always_comb begin
    accept  = (state == S_IDLE) && reqValid && !doneQ;
    newFast = !reqWrite && cfg.fastRd;
    zoneChg = lastValid && (reqZone != lastZone);
    gapN    = zoneChg ? (2'(cfg.preIdle) + 2'(cfg.postIdle)) : 2'd0;
    if (opFast)                 waitN = 3'd0;
    else if (opBurst && beatHi) waitN = {2'b00, cfg.burstWait};
    else                        waitN = cfg.waitCnt;
    holdN      = (opFast || (opBurst && beatHi)) ? 2'd0 : cfg.hold;
    lastStrobe = ((state == S_STROBE) && (waitN == 3'd0)) ||
                 ((state == S_WAIT) && (cnt == 3'd0));
    endBeat    = (lastStrobe && (holdN == 2'd0)) ||
                 ((state == S_HOLD) && (cnt == 3'd0));
    endStrobe  = lastStrobe && (holdN != 2'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      opWrite   <= 1'b0;
      opFast    <= 1'b0;
      opSplit   <= 1'b0;
      opBurst   <= 1'b0;
      beatHi    <= 1'b0;
      lastZone  <= '0;
      lastValid <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        opWrite   <= reqWrite;
        opFast    <= newFast;
        opSplit   <= reqWide && !cfg.busWide;
        opBurst   <= reqWide && !cfg.busWide && !reqWrite && cfg.burstEn && !newFast;
        beatHi    <= 1'b0;
        lastZone  <= reqZone;
        lastValid <= 1'b1;
        if (gapN != 2'd0) begin
          state <= S_GAP;
          cnt   <= 3'(gapN) - 3'd1;
        end else begin
          state <= newFast ? S_STROBE : S_SETUP;
        end
      end else if (endBeat) begin
        if (opSplit && !beatHi) begin
          beatHi <= 1'b1;
          state  <= (opFast || opBurst) ? S_STROBE : S_SETUP;
        end else begin
          state <= S_IDLE;
          doneQ <= 1'b1;
        end
      end else if (endStrobe) begin
        state <= S_HOLD;
        cnt   <= 3'(holdN) - 3'd1;
      end else begin
        case (state)
          S_GAP: begin
            if (cnt == 3'd0) state <= opFast ? S_STROBE : S_SETUP;
            else             cnt   <= cnt - 3'd1;
          end
          S_SETUP:  state <= S_STROBE;
          S_STROBE: begin
            state <= S_WAIT;
            cnt   <= waitN - 3'd1;
          end
          S_WAIT, S_HOLD: cnt <= cnt - 3'd1;
          default: ;
        endcase
      end
    end
  end

  logic strobePh;
  assign strobePh    = (state == S_STROBE) || (state == S_WAIT);
  assign busSel      = (state == S_SETUP) || strobePh || (state == S_HOLD);
  assign busRd       = strobePh && !opWrite;
  assign busWr       = strobePh && opWrite;
  assign busOe       = busSel && opWrite;
  assign done        = doneQ;
  assign ctl.load    = accept;
  assign ctl.capture = lastStrobe && !opWrite;
  assign ctl.beatHi  = beatHi;

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr)); // R8
  AST_STROBE_IN_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> busSel); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_AFTER_BUS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busSel)); // R8
  AST_GAP_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_GAP) |-> (lastValid && !busSel)); // R7
endmodule

// File: rtl/zoneseq_dp.sv
module zoneseq_dp
  import zoneseq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_t          ctl,
  input  logic          cfgBusWide,
  input  logic          busActive,
  input  logic [AW-1:0] reqAddr,
  input  logic          reqWide,
  input  logic [DW-1:0] reqWdata,
  input  logic [DW-1:0] busDin,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busDout,
  output logic [DW-1:0] rdData
);
  logic [AW-1:0] addrQ;
  logic [DW-1:0] wdQ;
  logic          wideQ;
  logic [DW-1:0] rdQ;
  logic          fullWord;
  logic [BYTE_W-1:0] loByte, hiByte, laneByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      wdQ   <= '0;
      wideQ <= 1'b0;
    end else if (ctl.load) begin
      addrQ <= reqAddr;
      wdQ   <= reqWdata;
      wideQ <= reqWide;
    end
  end

  assign fullWord = wideQ && cfgBusWide;
  assign loByte   = wdQ[BYTE_W-1:0];
  assign hiByte   = wdQ[DW-1:BYTE_W];
  assign busAddr  = wideQ ? {addrQ[AW-1:1], ctl.beatHi} : addrQ;
  assign busDout  = fullWord ? wdQ : (ctl.beatHi ? {hiByte, hiByte} : {loByte, loByte});
  assign laneByte = (cfgBusWide && addrQ[0]) ? busDin[DW-1:BYTE_W] : busDin[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else if (ctl.capture) begin
      if (fullWord)        rdQ <= busDin;
      else if (wideQ) begin
        if (ctl.beatHi)    rdQ[DW-1:BYTE_W] <= busDin[BYTE_W-1:0];
        else               rdQ[BYTE_W-1:0]  <= busDin[BYTE_W-1:0];
      end else             rdQ <= {{(DW-BYTE_W){1'b0}}, laneByte};
    end
  end

  assign rdData = rdQ;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busActive && $past(busActive) && $stable(ctl.beatHi)) |-> $stable(busAddr)); // R5
  AST_HI_BEAT_ODD: assert property (@(posedge clk) disable iff (!rstN)
    (busActive && ctl.beatHi) |-> busAddr[0]); // R5
endmodule

// File: rtl/zoneseq_top.sv
module zoneseq_top
  import zoneseq_pkg::*;
#(
  parameter int AW = 8,
  parameter int ZW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [15:0]   cfgWdata,
  output logic [15:0]   cfgRdata,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic          reqWide,
  input  logic [AW-1:0] reqAddr,
  input  logic [ZW-1:0] reqZone,
  input  logic [15:0]   reqWdata,
  output logic [15:0]   rdData,
  output logic          done,
  output logic [AW-1:0] busAddr,
  output logic          busSel,
  output logic          busRd,
  output logic          busWr,
  output logic [15:0]   busDout,
  input  logic [15:0]   busDin,
  output logic          busOe
);
  cfg_t cfg;
  ctl_t ctl;

  zoneseq_cfg i_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .cfg(cfg)
  );

  zoneseq_ctrl #(.ZW(ZW)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqZone(reqZone),
    .ctl(ctl), .busSel(busSel), .busRd(busRd), .busWr(busWr),
    .busOe(busOe), .done(done)
  );

  zoneseq_dp #(.AW(AW)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgBusWide(cfg.busWide),
    .busActive(busSel), .reqAddr(reqAddr), .reqWide(reqWide),
    .reqWdata(reqWdata), .busDin(busDin), .busAddr(busAddr),
    .busDout(busDout), .rdData(rdData)
  );
endmodule

// File: tb/test_zoneseq_top.sv
module test_zoneseq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqWide = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [1:0] reqZone = '0;
  logic [15:0] reqWdata = '0;
  logic [15:0] rdData;
  logic done;
  logic [7:0] busAddr;
  logic busSel, busRd, busWr, busOe;
  logic [15:0] busDout, busDin;

  always #4 clk = ~clk;

  zoneseq_top i_zoneseq_top (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqWide(reqWide), .reqAddr(reqAddr),
    .reqZone(reqZone), .reqWdata(reqWdata), .rdData(rdData), .done(done),
    .busAddr(busAddr), .busSel(busSel), .busRd(busRd), .busWr(busWr),
    .busDout(busDout), .busDin(busDin), .busOe(busOe)
  );

  int checks = 0, failures = 0;
  logic [7:0] mem [256];
  int cW, cH, cRbe, cWbr, cBw, cFre, cIpst, cIpre;
  int lastZone = 0;
  bit lastValid = 0;
  logic [15:0] lastRd;
  logic [7:0] firstAddr;

  assign busDin = (cBw != 0) ? {mem[{busAddr[7:1], 1'b1}], mem[{busAddr[7:1], 1'b0}]}
                             : {8'hEE, mem[busAddr]};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setCfg(input int w, input int h, input int rbe, input int wbr,
                        input int bw, input int fre, input int ipst, input int ipre);
    cW = w; cH = h; cRbe = rbe; cWbr = wbr; cBw = bw; cFre = fre; cIpst = ipst; cIpre = ipre;
    cfgWdata = {4'h0, fre[0], ipre[0], ipst[0], 1'b0, bw[0], wbr[0], rbe[0], h[1:0], w[2:0]};
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic run(input bit wr, input bit wide, input logic [7:0] a,
                     input logic [15:0] wd, input int z, input string tag);
    int fast, split, burst, b1, b2, s1, s2, gap, lat, selC, strC, gapC;
    bit seen, firstStr;
    fast  = (!wr && cFre != 0) ? 1 : 0;
    split = (wide && cBw == 0) ? 1 : 0;
    burst = (split != 0 && !wr && cRbe != 0 && fast == 0) ? 1 : 0;
    b1 = (fast != 0) ? 1 : 2 + cW + cH;
    s1 = (fast != 0) ? 1 : 1 + cW;
    b2 = (split == 0) ? 0 : (fast != 0) ? 1 : (burst != 0) ? 1 + cWbr : 2 + cW + cH;
    s2 = (split == 0) ? 0 : (fast != 0) ? 1 : (burst != 0) ? 1 + cWbr : 1 + cW;
    gap = (lastValid && z != lastZone) ? cIpre + cIpst : 0;
    lastZone = z; lastValid = 1;
    reqWrite = wr; reqWide = wide; reqAddr = a; reqWdata = wd; reqZone = z[1:0];
    reqValid = 1'b1;
    lat = 0; selC = 0; strC = 0; gapC = 0; seen = 0; firstStr = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      lat++;
      if (done) break;
      if (busSel) seen = 1;
      else if (!seen) gapC++;
      if (busSel) selC++;
      if (busRd || busWr) begin
        strC++;
        if (!firstStr) begin firstStr = 1; firstAddr = busAddr; end
      end
      if (busWr && busOe) begin
        if (cBw != 0 && wide) begin
          mem[{busAddr[7:1], 1'b0}] = busDout[7:0];
          mem[{busAddr[7:1], 1'b1}] = busDout[15:8];
        end else if (cBw != 0 && busAddr[0]) mem[busAddr] = busDout[15:8];
        else mem[busAddr] = busDout[7:0];
      end
    end
    reqValid = 1'b0;
    lastRd = rdData;
    chk(tag, "latency", lat, gap + b1 + b2 + 1);
    chk(tag, "select cycles", selC, b1 + b2);
    chk(tag, "strobe cycles", strC, s1 + s2);
    chk(tag, "idle cycles", gapC, gap);
    @(negedge clk);
    chk("R8", "done width", int'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 8'h31);
    cW = 7; cH = 3; cRbe = 0; cWbr = 0; cBw = 1; cFre = 0; cIpst = 1; cIpre = 1;
    repeat (3) @(negedge clk);
    chk("R1", "reset cfg", int'(cfgRdata), 16'h069F);
    chk("R8", "reset done", int'(done), 0);
    chk("R8", "reset select", int'(busSel), 0);
    rstN = 1'b1;
    @(negedge clk);

    // first access after reset: no idle cycles despite pre/post on (R7)
    run(0, 1, 8'h10, 16'h0, 1, "R7");
    chk("R4", "word data", int'(lastRd), {mem[8'h11], mem[8'h10]});

    // reserved bits masked (R1)
    cfgWdata = 16'hFFFF; cfgWe = 1'b1; @(negedge clk); cfgWe = 1'b0;
    chk("R1", "masked write", int'(cfgRdata), 16'h0EFF);

    // wait/hold sweep on 16-bit bus (R2, R4)
    for (int w = 0; w < 8; w++) begin
      for (int h = 0; h < 4; h++) begin
        logic [7:0] a;
        a = 8'((w * 4 + h) * 2);
        setCfg(w, h, 0, 0, 1, 0, 0, 0);
        run(0, 1, a, 16'h0, 1, "R2");
        chk("R4", "word data", int'(lastRd), {mem[a + 8'd1], mem[a]});
      end
    end

    // byte lane selection (R4)
    setCfg(1, 1, 0, 0, 1, 0, 0, 0);
    run(0, 0, 8'h21, 16'h0, 1, "R4");
    chk("R4", "odd byte", int'(lastRd), {8'h00, mem[8'h21]});
    run(0, 0, 8'h40, 16'h0, 1, "R4");
    chk("R4", "even byte", int'(lastRd), {8'h00, mem[8'h40]});

    // fast read ignores wait/hold; writes unaffected (R3)
    setCfg(7, 3, 0, 0, 1, 1, 0, 0);
    run(0, 1, 8'h30, 16'h0, 1, "R3");
    chk("R3", "fast data", int'(lastRd), {mem[8'h31], mem[8'h30]});
    run(1, 1, 8'h80, 16'hBEEF, 1, "R3");
    chk("R9", "word write", {mem[8'h81], mem[8'h80]}, 16'hBEEF);
    setCfg(2, 1, 0, 0, 0, 1, 0, 0);
    run(0, 1, 8'h33, 16'h0, 1, "R3");
    chk("R3", "fast split data", int'(lastRd), {mem[8'h33], mem[8'h32]});

    // split / burst sweep on 8-bit bus (R5, R6)
    for (int rbe = 0; rbe < 2; rbe++) begin
      for (int wbr = 0; wbr < 2; wbr++) begin
        for (int w = 0; w < 4; w++) begin
          for (int h = 0; h < 2; h++) begin
            logic [7:0] a;
            a = 8'(8'h50 + (w * 2 + h) * 2 + 1);
            setCfg(w, h, rbe, wbr, 0, 0, 0, 0);
            run(0, 1, a, 16'h0, 1, (rbe != 0) ? "R6" : "R5");
            chk("R5", "split data", int'(lastRd), {mem[{a[7:1], 1'b1}], mem[{a[7:1], 1'b0}]});
            chk("R5", "first beat address", int'(firstAddr), int'({a[7:1], 1'b0}));
          end
        end
      end
    end

    // burst does not apply to writes or a 16-bit bus (R6)
    setCfg(2, 2, 1, 1, 0, 0, 0, 0);
    run(1, 1, 8'h90, 16'hA55A, 1, "R6");
    chk("R9", "split write", {mem[8'h91], mem[8'h90]}, 16'hA55A);
    setCfg(2, 2, 1, 1, 1, 0, 0, 0);
    run(0, 1, 8'h90, 16'h0, 1, "R6");
    chk("R6", "wide bus word", int'(lastRd), 16'hA55A);

    // byte write lane (R9)
    setCfg(0, 0, 0, 0, 1, 0, 0, 0);
    run(1, 0, 8'hA3, 16'h0077, 1, "R9");
    chk("R9", "byte write", int'(mem[8'hA3]), 8'h77);

    // idle insertion on zone changes (R7)
    for (int pre = 0; pre < 2; pre++) begin
      for (int post = 0; post < 2; post++) begin
        setCfg(1, 0, 0, 0, 1, 0, post, pre);
        run(0, 1, 8'h12, 16'h0, 0, "R7");
        run(0, 1, 8'h14, 16'h0, 2, "R7");
        run(0, 1, 8'h16, 16'h0, 2, "R7");
        setCfg(1, 0, 0, 0, 1, 1, post, pre);
        run(0, 1, 8'h18, 16'h0, 3, "R7");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule